// File: doc/BRIEF.md
# Bus Cycle Ready and Reset Synchronizer

This block tells a processor when its current bus cycle may end and supplies the system reset. A bus cycle begins when the two active-low status lines leave their idle code (both high). From that point the block keeps the ready line released until a qualified ready request arrives. It then pulls the ready line low for a fixed number of clock periods and releases it again. Two request paths feed it. One is asynchronous and passes through a two-flop synchronizer. The other is synchronous and is captured in a single register. Each path counts only while its own active-low enable is also low.

The ready output is an open-drain enable. When `ready_pull` is 1 the external line is pulled low, meaning ready is asserted. When it is 0 the line floats and the pull-up holds it inactive. The system reset output goes high as soon as the active-low reset input falls, and it goes low only after a synchronizer has seen the input high for several clock edges. While reset is high, the ready line is pulled low.

Top module: `cycle_ready_gen`

## Requirements
- R1: `sys_reset` goes to 1 as soon as `rst_in_n` falls, without waiting for a clock edge.
- R2: Once `rst_in_n` rises, `sys_reset` stays 1 through the first rising clock edge and falls after the second one (RST_STAGES = 2).
- R3: While `sys_reset` is 1, `ready_pull` is 1 whatever the other inputs are.
- R4: Outside reset, `ready_pull` stays 0 until a bus cycle has started, even when a ready request is qualified. A cycle starts when the registered `stat_n` moves from idle code 2'b11 to any other code.
- R5: Inside a bus cycle, a qualified synchronous request (`sync_rdy_n` = 0 and `sync_rdy_en_n` = 0, set up before edge E1) makes `ready_pull` 1 after edge E2.
- R6: Inside a bus cycle, a qualified asynchronous request (`async_rdy_n` = 0 and `async_rdy_en_n` = 0, applied before edge E1) makes `ready_pull` 1 after edge E3.
- R7: A request counts only when both the request line and its own enable are low. A request line that is low while its enable is high, or an enable that is low while its request line is high, leaves `ready_pull` at 0.
- R8: Once raised outside reset, `ready_pull` stays 1 for exactly READY_LEN = 2 clock periods and then returns to 0. It stays at 0 even if the request remains qualified, until a new bus cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_in_n | input | 1 | Asynchronous active-low reset request |
| stat_n | input | 2 | Active-low bus status; 2'b11 means idle, any other value starts a cycle |
| async_rdy_n | input | 1 | Asynchronous ready request, active low |
| async_rdy_en_n | input | 1 | Enable for the asynchronous request, active low |
| sync_rdy_n | input | 1 | Synchronous ready request, active low |
| sync_rdy_en_n | input | 1 | Enable for the synchronous request, active low |
| ready_pull | output | 1 | Open-drain enable: 1 pulls the ready line low (ready asserted) |
| sys_reset | output | 1 | System reset, active high |

## Verification
The cases that are hardest to reach from the ports are the ones where the ready line must stay quiet although a request is fully qualified. This happens either before any cycle has begun or after the current cycle has already been answered. The bench holds both request paths qualified across those windows and samples every cycle to confirm that no further assertion appears. The latency difference between the two synchronizer depths is reached by first parking the block in the waiting state with a status edge. The request is then applied on a falling edge and rising edges are counted one by one, so that an extra or missing stage shows up as a shift of one cycle.

// File: rtl/cycle_ready_pkg.sv
package cycle_ready_pkg;

  // Bus-cycle tracking states
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,  // no bus cycle in progress
    CYC_WAIT  = 2'd1,  // cycle started, ready not yet qualified
    CYC_DRIVE = 2'd2   // ready line being pulled low
  } cyc_state_t;

  // Status code meaning "no bus cycle"
  localparam logic [1:0] STAT_IDLE = 2'b11;

endpackage

// File: rtl/cycle_ready_sync.sv
// Multi-stage register chain with asynchronous reset to a chosen value.
module cycle_ready_sync #(
  parameter int          WIDTH   = 2,
  parameter int          DEPTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg[0] <= RST_VAL;
    end else begin
      stg[0] <= d;
    end
  end

  for (genvar gi = 1; gi < DEPTH; gi++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[gi] <= RST_VAL;
      end else begin
        stg[gi] <= stg[gi-1];
      end
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/cycle_ready_rst.sv
// Reset conditioner: asserts immediately, releases after STAGES clock edges.
module cycle_ready_rst #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic res_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge res_n) begin
    if (!res_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_out_n = chain_q[STAGES-1];

endmodule

// File: rtl/cycle_ready_fsm.sv
// Tracks bus-cycle framing and times the ready pulse.
module cycle_ready_fsm
  import cycle_ready_pkg::*;
#(
  parameter int READY_LEN = 2,
  localparam int CW = $clog2(READY_LEN + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] stat_cur,     // registered status
  input  logic       a_en_n,       // synchronized async enable
  input  logic       a_rdy_n,      // synchronized async request
  input  logic       s_en_n,       // registered sync enable
  input  logic       s_rdy_n,      // registered sync request
  output logic       drive
);

  cyc_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [1:0]    stat_prev_q;
  logic          cyc_start;
  logic          qual;

  assign cyc_start = (stat_cur != STAT_IDLE) && (stat_prev_q == STAT_IDLE);
  assign qual      = (!a_en_n && !a_rdy_n) || (!s_en_n && !s_rdy_n);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      CYC_IDLE: begin
        if (cyc_start) state_d = CYC_WAIT;
      end
      CYC_WAIT: begin
        if (qual) begin
          state_d = CYC_DRIVE;
          cnt_d   = CW'(READY_LEN - 1);
          cnt_en  = 1'b1;
        end
      end
      CYC_DRIVE: begin
        if (cnt_q == '0) begin
          state_d = cyc_start ? CYC_WAIT : CYC_IDLE;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = CYC_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= CYC_IDLE;
      stat_prev_q <= STAT_IDLE;
    end else begin
      state_q     <= state_d;
      stat_prev_q <= stat_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign drive = (state_q == CYC_DRIVE);

endmodule

// File: rtl/cycle_ready_gen.sv
module cycle_ready_gen
  import cycle_ready_pkg::*;
#(
  parameter int ASYNC_STAGES = 2,
  parameter int SYNC_STAGES  = 1,
  parameter int RST_STAGES   = 2,
  parameter int READY_LEN    = 2
) (
  input  logic       clk,
  input  logic       rst_in_n,
  input  logic [1:0] stat_n,
  input  logic       async_rdy_n,
  input  logic       async_rdy_en_n,
  input  logic       sync_rdy_n,
  input  logic       sync_rdy_en_n,
  output logic       ready_pull,
  output logic       sys_reset
);

  logic       rst_int_n;
  logic [1:0] stat_q;
  logic [1:0] async_q;   // {enable, request}
  logic [1:0] sync_q;    // {enable, request}
  logic       drive;

  cycle_ready_rst #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .res_n     (rst_in_n),
    .rst_out_n (rst_int_n)
  );

  cycle_ready_sync #(.WIDTH(2), .DEPTH(SYNC_STAGES), .RST_VAL(STAT_IDLE)) u_stat (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (stat_n),
    .q     (stat_q)
  );

  cycle_ready_sync #(.WIDTH(2), .DEPTH(ASYNC_STAGES), .RST_VAL(2'b11)) u_async (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({async_rdy_en_n, async_rdy_n}),
    .q     (async_q)
  );

  cycle_ready_sync #(.WIDTH(2), .DEPTH(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({sync_rdy_en_n, sync_rdy_n}),
    .q     (sync_q)
  );

  cycle_ready_fsm #(.READY_LEN(READY_LEN)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .stat_cur (stat_q),
    .a_en_n   (async_q[1]),
    .a_rdy_n  (async_q[0]),
    .s_en_n   (sync_q[1]),
    .s_rdy_n  (sync_q[0]),
    .drive    (drive)
  );

  assign sys_reset  = !rst_int_n;
  assign ready_pull = sys_reset || drive;

endmodule

// File: rtl/cycle_ready_chk.sv
module cycle_ready_chk #(
  parameter int READY_LEN = 2,
  localparam int RW = $clog2(READY_LEN + 2)
) (
  input logic       clk,
  input logic       rst_in_n,
  input logic       sys_reset,
  input logic       ready_pull,
  input logic [1:0] async_q,
  input logic [1:0] sync_q
);

  logic          src_ok;
  logic [RW-1:0] run_q;

  assign src_ok = (async_q == 2'b00) || (sync_q == 2'b00);

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      run_q <= '0;
    end else if (ready_pull && !sys_reset) begin
      if (run_q != RW'(READY_LEN + 1)) run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  // R3: reset forces the ready line low
  p_reset_holds_ready_r3: assert property (@(posedge clk) disable iff (!rst_in_n)
    sys_reset |-> ready_pull);

  // R4 / R7: a new ready assertion outside reset needs a qualified source
  p_ready_has_source_r7: assert property (@(posedge clk) disable iff (!rst_in_n)
    ($rose(ready_pull) && !sys_reset) |-> $past(src_ok));

  // R8: pulse never outlasts READY_LEN periods
  p_pulse_length_r8: assert property (@(posedge clk) disable iff (!rst_in_n)
    (ready_pull && !sys_reset) |-> (run_q < RW'(READY_LEN)));

  // R2: reset release only after the input was already high
  p_reset_release_r2: assert property (@(posedge clk) disable iff (!rst_in_n)
    $fell(sys_reset) |-> $past(rst_in_n));

endmodule

bind cycle_ready_gen cycle_ready_chk #(.READY_LEN(READY_LEN)) u_chk (
  .clk        (clk),
  .rst_in_n   (rst_in_n),
  .sys_reset  (sys_reset),
  .ready_pull (ready_pull),
  .async_q    (async_q),
  .sync_q     (sync_q)
);

// File: tb/cycle_ready_gen_test.sv
`timescale 1ns/1ps
module cycle_ready_gen_test;

  logic       clk = 1'b0;
  logic       rst_in_n;
  logic [1:0] stat_n;
  logic       async_rdy_n, async_rdy_en_n, sync_rdy_n, sync_rdy_en_n;
  logic       ready_pull, sys_reset;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cycle_ready_gen uut (
    .clk            (clk),
    .rst_in_n       (rst_in_n),
    .stat_n         (stat_n),
    .async_rdy_n    (async_rdy_n),
    .async_rdy_en_n (async_rdy_en_n),
    .sync_rdy_n     (sync_rdy_n),
    .sync_rdy_en_n  (sync_rdy_en_n),
    .ready_pull     (ready_pull),
    .sys_reset      (sys_reset)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    stat_n = 2'b11;
    async_rdy_n = 1'b1; async_rdy_en_n = 1'b1;
    sync_rdy_n  = 1'b1; sync_rdy_en_n  = 1'b1;
  endtask

  // start a bus cycle; returns at a falling edge with the block waiting
  task automatic start_cycle();
    stat_n = 2'b01;
    step(1);
    stat_n = 2'b11;
    step(1);
  endtask

  // R1, R2, R3: reset entry and release
  task automatic t_reset();
    @(negedge clk);
    #1 rst_in_n = 1'b0;
    #0.5;
    chk("R1 reset asserts asynchronously", sys_reset, 1'b1);
    chk("R3 ready pulled during reset", ready_pull, 1'b1);
    sync_rdy_n = 1'b1; async_rdy_en_n = 1'b0;
    step(3);
    chk("R3 ready held in reset across edges", ready_pull, 1'b1);
    rst_in_n = 1'b1;
    idle_inputs();
    step(1);
    chk("R2 reset still high after one edge", sys_reset, 1'b1);
    step(1);
    chk("R2 reset low after two edges", sys_reset, 1'b0);
    chk("R3 ready released after reset", ready_pull, 1'b0);
  endtask

  // R4: qualified request without a cycle start
  task automatic t_no_cycle();
    sync_rdy_n = 1'b0; sync_rdy_en_n = 1'b0;
    async_rdy_n = 1'b0; async_rdy_en_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step(1);
      chk("R4 no ready outside a bus cycle", ready_pull, 1'b0);
    end
    idle_inputs();
    step(3);
  endtask

  // R5, R8: synchronous path latency and pulse length
  task automatic t_sync();
    start_cycle();
    sync_rdy_n = 1'b0; sync_rdy_en_n = 1'b0;
    step(1);
    chk("R5 sync not yet after E1", ready_pull, 1'b0);
    step(1);
    chk("R5 sync ready after E2", ready_pull, 1'b1);
    step(1);
    chk("R8 pulse second period", ready_pull, 1'b1);
    step(1);
    chk("R8 pulse released", ready_pull, 1'b0);
    for (int i = 0; i < 4; i++) begin
      step(1);
      chk("R8 no repeat for held request", ready_pull, 1'b0);
    end
    idle_inputs();
    step(2);
  endtask

  // R6, R8: asynchronous path latency
  task automatic t_async();
    start_cycle();
    async_rdy_n = 1'b0; async_rdy_en_n = 1'b0;
    step(2);
    chk("R6 async not yet after E2", ready_pull, 1'b0);
    step(1);
    chk("R6 async ready after E3", ready_pull, 1'b1);
    step(1);
    chk("R8 async pulse second period", ready_pull, 1'b1);
    step(1);
    chk("R8 async pulse released", ready_pull, 1'b0);
    idle_inputs();
    step(3);
  endtask

  // R7: request and enable must both be low
  task automatic t_qualify();
    start_cycle();
    sync_rdy_n = 1'b0;  sync_rdy_en_n = 1'b1;
    async_rdy_n = 1'b1; async_rdy_en_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step(1);
      chk("R7 unqualified mix gives no ready", ready_pull, 1'b0);
    end
    sync_rdy_n = 1'b1;  sync_rdy_en_n = 1'b0;
    async_rdy_n = 1'b0; async_rdy_en_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(1);
      chk("R7 swapped mix gives no ready", ready_pull, 1'b0);
    end
    sync_rdy_n = 1'b0;
    step(2);
    chk("R7 qualified sync completes cycle", ready_pull, 1'b1);
    idle_inputs();
    step(4);
    chk("R8 idle after cycle", ready_pull, 1'b0);
  endtask

  // R3: reset in the middle of a waiting cycle
  task automatic t_reset_mid();
    start_cycle();
    step(1);
    chk("R4 waiting cycle keeps ready off", ready_pull, 1'b0);
    #1 rst_in_n = 1'b0;
    #0.5;
    chk("R3 reset overrides waiting cycle", ready_pull, 1'b1);
    chk("R1 mid-run reset asserts at once", sys_reset, 1'b1);
    @(negedge clk);
    rst_in_n = 1'b1;
    step(2);
    chk("R2 reset released after mid-run pulse", sys_reset, 1'b0);
    sync_rdy_n = 1'b0; sync_rdy_en_n = 1'b0;
    step(3);
    chk("R4 aborted cycle not resumed", ready_pull, 1'b0);
    idle_inputs();
    step(2);
  endtask

  initial begin
    rst_in_n = 1'b0;
    idle_inputs();
    step(3);
    chk("R3 ready pulled at start-up", ready_pull, 1'b1);
    chk("R1 reset high at start-up", sys_reset, 1'b1);
    rst_in_n = 1'b1;
    step(2);
    chk("R2 reset released", sys_reset, 1'b0);
    t_no_cycle();
    t_sync();
    t_async();
    t_qualify();
    t_reset();
    t_sync();
    t_reset_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule